// File: doc/BRIEF.md
# Register-Condition Branch Unit

This block resolves a branch that tests a full 64-bit general register against zero. The fetch stage presents one 32-bit instruction word together with the address of that instruction and the value read for its source register. The unit checks that the word is a well-formed register-condition branch, evaluates the selected signed comparison against zero, and forms the PC-relative target from a displacement that is split across two separate fields of the word.

One clock later it reports whether the branch redirects, where it goes, and whether the single instruction in the delay slot must be squashed. The redirect takes effect after the delay-slot instruction. A taken branch never squashes its delay slot. A not-taken branch squashes it only when the annul bit is set. The static prediction bit is forwarded as a hint and has no effect on the result. Malformed words are flagged and never redirect or squash anything.

Top module: `regbr_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, taken, annul_next, illegal, predict_hint and target are all zero.
- R2: out_valid is high on the cycle after each clock edge that samples in_valid high, and all other results for that word are presented on the same cycle.
- R3: The condition field is instr[27:25]. With rs1 read as a signed 64-bit value, code 1 tests equal to zero, 2 less than or equal to zero, 3 less than zero, 5 not equal to zero, 6 greater than zero and 7 greater than or equal to zero. taken is 1 exactly when the word is legal and the test holds.
- R4: The displacement is {instr[21:20], instr[13:0]}, a signed 16-bit word count. For each valid word, target equals pc + (sign-extended displacement × 4), taken modulo 2^64, whether or not the branch is taken or legal.
- R5: A word is illegal when instr[31:30] is not 00, when instr[24:22] is not 011, when instr[28] is 1, or when the condition code is 0 or 4. For such a word illegal is 1 and taken and annul_next are 0.
- R6: annul_next is 1 exactly when the word is legal, its test fails and the annul bit instr[29] is 1. When the test fails with the annul bit clear, annul_next is 0.
- R7: When the test holds, annul_next is 0 even with instr[29] set.
- R8: predict_hint equals instr[19] of the sampled word. Flipping instr[19] leaves taken, annul_next, illegal and target unchanged.
- R9: After an edge that samples in_valid low, out_valid, taken, annul_next, illegal and predict_hint are 0 and target keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| pc | input | 64 | Address of the branch instruction |
| rs1_val | input | 64 | Value of the source register |
| out_valid | output | 1 | Results below belong to a sampled word |
| taken | output | 1 | Redirect after the delay slot |
| target | output | 64 | Branch destination |
| annul_next | output | 1 | Squash the delay-slot instruction |
| illegal | output | 1 | Word is not a legal encoding |
| predict_hint | output | 1 | Static prediction bit of the word |

## Verification
Every result passes through exactly one register, so each output for a word driven before edge k is due in the cycle that follows edge k. The bench drives each word on a falling edge and uses a behavioural model to work out that word's expected outputs. It compares every output on the next falling edge, after the register has loaded and before the next word is driven. Idle cycles are checked the same way: the flags must drop and the target must hold its value.

// File: rtl/regbr_pkg.sv
package regbr_pkg;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned DISP_W    = 16;
  localparam int unsigned DISP_LO_W = 14;

  localparam logic [1:0] OP_MAJOR_BR = 2'b00;
  localparam logic [2:0] OP_MINOR_RB = 3'b011;

  typedef enum logic [2:0] {
    RC_RSV0 = 3'd0,
    RC_EQZ  = 3'd1,
    RC_LEZ  = 3'd2,
    RC_LTZ  = 3'd3,
    RC_RSV4 = 3'd4,
    RC_NEZ  = 3'd5,
    RC_GTZ  = 3'd6,
    RC_GEZ  = 3'd7
  } rcond_e;

  typedef struct packed {
    logic   legal;
    logic   annul;
    logic   predict;
    rcond_e cond;
  } decoded_t;
endpackage

// File: rtl/regbr_decode.sv
module regbr_decode
  import regbr_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output decoded_t          dec
);
  logic   major_ok, minor_ok, rsv_ok, cond_ok;
  rcond_e cond;

  assign cond     = rcond_e'(instr[27:25]);
  assign major_ok = (instr[31:30] == OP_MAJOR_BR);
  assign minor_ok = (instr[24:22] == OP_MINOR_RB);
  assign rsv_ok   = ~instr[28];

  always_comb begin
    case (cond)
      RC_RSV0, RC_RSV4: cond_ok = 1'b0;
      default:          cond_ok = 1'b1;
    endcase
  end

  assign dec.legal   = major_ok & minor_ok & rsv_ok & cond_ok;
  assign dec.annul   = instr[29];
  assign dec.predict = instr[19];
  assign dec.cond    = cond;

  // R5: a reserved condition code is never reported legal
  always_comb begin
    if (!$isunknown(instr))
      a_r5_rsv_cond_rejected: assert (!(dec.legal && (instr[26:25] == 2'b00)));
  end
endmodule

// File: rtl/regbr_zero_cmp.sv
module regbr_zero_cmp
  import regbr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] rs1_val,
  input  rcond_e          cond,
  output logic            hold
);
  logic is_zero, is_neg, is_pos;

  assign is_zero = (rs1_val == '0);
  assign is_neg  = rs1_val[XLEN-1];
  assign is_pos  = ~is_zero & ~is_neg;

  always_comb begin
    case (cond)
      RC_EQZ:  hold = is_zero;
      RC_LEZ:  hold = is_zero | is_neg;
      RC_LTZ:  hold = is_neg;
      RC_NEZ:  hold = ~is_zero;
      RC_GTZ:  hold = is_pos;
      RC_GEZ:  hold = ~is_neg;
      default: hold = 1'b0;
    endcase
  end

  // R3: the sign classes partition every register value
  always_comb begin
    if (!$isunknown(rs1_val))
      a_r3_sign_partition: assert ($onehot({is_zero, is_neg, is_pos}));
  end
endmodule

// File: rtl/regbr_target.sv
module regbr_target
  import regbr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [INSN_W-1:0] instr,
  input  logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   target
);
  localparam int unsigned HI_W  = DISP_W - DISP_LO_W;
  localparam int unsigned EXT_W = XLEN - DISP_W - 2;

  logic [HI_W-1:0]      disp_hi;
  logic [DISP_LO_W-1:0] disp_lo;
  logic [DISP_W-1:0]    disp;
  logic [XLEN-1:0]      offset;

  assign disp_hi = instr[20 +: HI_W];
  assign disp_lo = instr[DISP_LO_W-1:0];
  assign disp    = {disp_hi, disp_lo};
  assign offset  = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
  assign target  = pc + offset;

  // R4: a word-aligned offset keeps the byte offset of the pc
  always_comb begin
    if (!$isunknown({instr, pc}))
      a_r4_align_kept: assert (target[1:0] == pc[1:0]);
  end
endmodule

// File: rtl/regbr_unit.sv
module regbr_unit
  import regbr_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] instr,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rs1_val,
  output logic              out_valid,
  output logic              taken,
  output logic [XLEN-1:0]   target,
  output logic              annul_next,
  output logic              illegal,
  output logic              predict_hint
);
  decoded_t        dec;
  logic            cond_hold;
  logic [XLEN-1:0] tgt_c;

  logic            valid_q, taken_q, annul_q, ill_q, hint_q;
  logic [XLEN-1:0] target_q;

  regbr_decode u_decode (
    .instr (instr),
    .dec   (dec)
  );

  regbr_zero_cmp #(.XLEN(XLEN)) u_cmp (
    .rs1_val (rs1_val),
    .cond    (dec.cond),
    .hold    (cond_hold)
  );

  regbr_target #(.XLEN(XLEN)) u_tgt (
    .instr  (instr),
    .pc     (pc),
    .target (tgt_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      taken_q  <= 1'b0;
      annul_q  <= 1'b0;
      ill_q    <= 1'b0;
      hint_q   <= 1'b0;
      target_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        taken_q  <= dec.legal & cond_hold;
        annul_q  <= dec.legal & ~cond_hold & dec.annul;
        ill_q    <= ~dec.legal;
        hint_q   <= dec.predict;
        target_q <= tgt_c;
      end else begin
        taken_q <= 1'b0;
        annul_q <= 1'b0;
        ill_q   <= 1'b0;
        hint_q  <= 1'b0;
      end
    end
  end

  assign out_valid    = valid_q;
  assign taken        = taken_q;
  assign target       = target_q;
  assign annul_next   = annul_q;
  assign illegal      = ill_q;
  assign predict_hint = hint_q;

  a_r2_valid_next: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r5_illegal_inert: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!taken && !annul_next));

  a_r7_taken_keeps_slot: assert property (@(posedge clk) disable iff (rst)
    taken |-> !annul_next);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!taken && !annul_next && !illegal && !predict_hint));

  a_r9_target_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(target));
endmodule

// File: tb/regbr_unit_bench.sv
module regbr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] pc = '0;
  logic [63:0] rs1_val = '0;
  logic        out_valid, taken, annul_next, illegal, predict_hint;
  logic [63:0] target;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [63:0] e_target = '0;

  always #10 clk = ~clk;

  regbr_unit u_regbr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc),
    .rs1_val(rs1_val), .out_valid(out_valid), .taken(taken), .target(target),
    .annul_next(annul_next), .illegal(illegal), .predict_hint(predict_hint)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic a, input logic [2:0] rc,
                                     input logic p, input logic [15:0] d);
    return {2'b00, a, 1'b0, rc, 3'b011, d[15:14], p, 5'd3, d[13:0]};
  endfunction

  function automatic logic ref_test(input logic [2:0] rc, input logic [63:0] v);
    case (rc)
      3'd1: return $signed(v) == 64'sd0;
      3'd2: return $signed(v) <= 64'sd0;
      3'd3: return $signed(v) <  64'sd0;
      3'd5: return $signed(v) != 64'sd0;
      3'd6: return $signed(v) >  64'sd0;
      3'd7: return $signed(v) >= 64'sd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ref_legal(input logic [31:0] w);
    return (w[31:30] == 2'b00) && (w[24:22] == 3'b011) && !w[28]
           && (w[27:25] != 3'd0) && (w[27:25] != 3'd4);
  endfunction

  // One cycle: drive on a falling edge, compare on the next falling edge.
  task automatic step(input logic v, input logic [31:0] w, input logic [63:0] p,
                      input logic [63:0] r, input string tag);
    logic lg, c, e_tk, e_an, e_il, e_hn;
    logic [15:0] d;
    in_valid = v; instr = w; pc = p; rs1_val = r;
    lg = ref_legal(w);
    c  = ref_test(w[27:25], r);
    d  = {w[21:20], w[13:0]};
    if (v) begin
      e_tk = lg && c;
      e_an = lg && !c && w[29];
      e_il = !lg;
      e_hn = w[19];
      e_target = p + {{46{d[15]}}, d, 2'b00};
    end else begin
      e_tk = 0; e_an = 0; e_il = 0; e_hn = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(v ? "R2" : "R9", "out_valid", 64'(out_valid), 64'(v));
    chk(tag, "taken", 64'(taken), 64'(e_tk));
    chk(tag, "annul_next", 64'(annul_next), 64'(e_an));
    chk(v ? "R5" : "R9", "illegal", 64'(illegal), 64'(e_il));
    chk(v ? "R8" : "R9", "predict_hint", 64'(predict_hint), 64'(e_hn));
    chk(v ? "R4" : "R9", "target", target, e_target);
  endtask

  initial begin
    logic [63:0] vals [5];
    vals[0] = 64'd0; vals[1] = 64'd1; vals[2] = '1;
    vals[3] = 64'h7fff_ffff_ffff_ffff; vals[4] = 64'h8000_0000_0000_0000;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "out_valid", 64'(out_valid), 0);
    chk("R1", "taken", 64'(taken), 0);
    chk("R1", "annul_next", 64'(annul_next), 0);
    chk("R1", "illegal", 64'(illegal), 0);
    chk("R1", "predict_hint", 64'(predict_hint), 0);
    chk("R1", "target", target, 0);
    rst = 1'b0;
    step(0, '0, '0, '0, "R1");

    // R3: every legal and reserved code against the sign boundaries
    for (int rc = 0; rc < 8; rc++)
      for (int k = 0; k < 5; k++)
        step(1, mk(0, 3'(rc), 0, 16'h0010), 64'h1000, vals[k],
             (rc == 0 || rc == 4) ? "R5" : "R3");

    // R6 / R7: annul bit with failing and holding tests
    step(1, mk(1, 3'd1, 0, 16'h0004), 64'h2000, 64'd5, "R6");
    step(1, mk(0, 3'd1, 0, 16'h0004), 64'h2000, 64'd5, "R6");
    step(1, mk(1, 3'd3, 1, 16'h0004), 64'h2000, 64'd0, "R6");
    step(1, mk(1, 3'd1, 0, 16'h0004), 64'h2000, 64'd0, "R7");
    step(1, mk(1, 3'd6, 1, 16'h0004), 64'h2000, 64'd9, "R7");

    // R4: displacement extremes and wraparound
    step(1, mk(0, 3'd7, 0, 16'h8000), 64'h0000_0000_0001_0000, 64'd1, "R4");
    step(1, mk(0, 3'd7, 0, 16'h7fff), 64'hffff_ffff_ffff_fff0, 64'd1, "R4");
    step(1, mk(0, 3'd5, 0, 16'hffff), 64'h0, 64'd1, "R4");
    step(1, mk(0, 3'd5, 0, 16'h4001), 64'h1234_5678_9abc_def0, 64'd1, "R4");

    // R5: malformed fields
    step(1, mk(0, 3'd1, 0, 16'h0) | 32'h1000_0000, 64'h40, 64'd0, "R5");
    step(1, mk(1, 3'd5, 0, 16'h0) | 32'h4000_0000, 64'h40, 64'd3, "R5");
    step(1, mk(0, 3'd1, 0, 16'h0) ^ 32'h0040_0000, 64'h40, 64'd0, "R5");
    step(1, mk(1, 3'd4, 0, 16'h0), 64'h40, 64'd2, "R5");

    // R8: prediction bit flipped on otherwise identical words
    step(1, mk(1, 3'd2, 0, 16'h0123), 64'h800, 64'd7, "R8");
    step(1, mk(1, 3'd2, 1, 16'h0123), 64'h800, 64'd7, "R8");
    step(1, mk(0, 3'd2, 1, 16'h0123), 64'h800, '1, "R8");
    step(1, mk(0, 3'd2, 0, 16'h0123), 64'h800, '1, "R8");

    // R9: bubbles with garbage on the inputs hold the target
    step(0, mk(0, 3'd1, 1, 16'h7777), 64'hdead, 64'd0, "R9");
    step(0, '1, '1, '1, "R9");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      w = mk(1'($urandom), 3'($urandom), 1'($urandom), 16'($urandom));
      if ($urandom_range(0, 9) == 0) w = w ^ (32'h1 << $urandom_range(22, 31));
      step(($urandom_range(0, 5) != 0), w, {$urandom, $urandom},
           ($urandom_range(0, 3) == 0) ? 64'd0 : {$urandom, $urandom},
           "R3");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule